// File: doc/BRIEF.md
# Cartridge ROM Bank Controller with Nibble RAM

This block sits between an 8-bit CPU bus (16-bit address, write data, read data, read and write strobes) and an external cartridge ROM. The lower 16 KB of the CPU's ROM space always shows ROM bank 0. The upper 16 KB shows a bank chosen by a software-written register. The block drives the full ROM address, with the bank number on bits 17:14. It also holds a small on-chip RAM of 512 four-bit cells that software must unlock before use.

Software controls the block by writing to 0x0000–0x3FFF. Address bit 8 alone decides which of the two controls a write reaches. When bit 8 is 0 the write sets the RAM unlock. When bit 8 is 1 the write loads the bank register. The RAM appears anywhere in 0xA000–0xBFFF and is indexed by address bits 8:0, so the 512 cells repeat through the whole window. The ROM size is set by a parameter and may be any power of two from 2 to 16 banks.

Writes take effect on the rising clock edge. Read data and the ROM address are combinational from the current address and the register state.

Top module: `cbc_ctrl`

## Requirements
- R1: After reset the bank register holds 0 and the RAM is locked. A read at 0x4000 therefore returns bank 1 data, and a read in 0xA000–0xBFFF returns 0xFF.
- R2: While CPU address bit 14 is 0, rom_addr[17:14] is 0. rom_addr[13:0] always equals cpu_addr[13:0].
- R3: A write to 0x0000–0x3FFF with address bit 8 set stores wdata[3:0] in the bank register. While address bit 14 is 1, rom_addr[17:14] equals the promoted value ANDed with ROM_BANKS-1. The promoted value is 1 when the register holds 0, and the register value otherwise. For example, with 4 banks, 5 selects 1 and 0x1F selects 3.
- R4: A write to 0x0000–0x3FFF with address bit 8 clear unlocks the RAM when wdata[3:0] is 0xA and locks it for any other value. wdata[7:4] has no effect.
- R5: A write that reaches the RAM unlock leaves the bank register unchanged. A write that reaches the bank register leaves the RAM unlock unchanged.
- R6: While the RAM is unlocked, a write in 0xA000–0xBFFF stores wdata[3:0] at index cpu_addr[8:0]. A read there returns {4'hF, stored nibble}, so 0xA200 aliases 0xA000.
- R7: While the RAM is locked, RAM reads return 0xFF and RAM writes leave the stored contents unchanged.
- R8: Writes to 0x4000–0x9FFF and to 0xC000–0xFFFF change neither the bank register, the RAM unlock nor the RAM contents.
- R9: While cpu_rd is high, cpu_rdata equals rom_rdata for addresses below 0x8000 and equals 0xFF for 0x8000–0x9FFF and 0xC000–0xFFFF. While cpu_rd is low, cpu_rdata is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the clock edge |
| cpu_rd | input | 1 | Read strobe, enables cpu_rdata |
| rom_rdata | input | 8 | Data returned by the external ROM |
| cpu_rdata | output | 8 | Read data to the CPU |
| rom_addr | output | 18 | External ROM address, bank number on bits 17:14 |

## Verification
The assertions assume that reset is held high for at least one clock edge before any write is checked. They also assume that each address and strobe holds steady from one falling edge to the next, so that a write at a rising edge belongs to exactly one decoded window. The bench changes its inputs only on falling edges and holds reset for several cycles. It spreads its random addresses over the register, ROM, RAM and unmapped windows. About a quarter of the random unlock writes carry a low nibble of 0xA, so the RAM is seen both locked and unlocked.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int REG_W = 4;
  localparam logic [REG_W-1:0] UNLOCK_KEY = 4'hA;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  function automatic logic in_reg_win(input logic [15:0] a);
    return a[15:14] == 2'b00;
  endfunction

  function automatic logic in_rom_win(input logic [15:0] a);
    return a[15] == 1'b0;
  endfunction

  function automatic logic in_ram_win(input logic [15:0] a);
    return a[15:13] == 3'b101;
  endfunction
endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_gate,
  input  logic             wr_bank,
  input  logic [REG_W-1:0] wdata_lo,
  output logic [REG_W-1:0] bank_q,
  output logic             ram_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      ram_en <= 1'b0;
    end else begin
      if (wr_gate) ram_en <= (wdata_lo == UNLOCK_KEY);
      if (wr_bank) bank_q <= wdata_lo;
    end
  end
endmodule

// File: rtl/cbc_bankmap.sv
module cbc_bankmap #(
  parameter int ROM_BANKS = 16,
  parameter int REG_W     = 4
) (
  input  logic [REG_W-1:0] raw,
  output logic [REG_W-1:0] eff
);
  localparam logic [REG_W-1:0] BANK_MASK = REG_W'(ROM_BANKS - 1);
  logic [REG_W-1:0] promoted;

  assign promoted = (raw == '0) ? REG_W'(1) : raw;

  generate
    if (ROM_BANKS >= (1 << REG_W)) begin : g_full
      assign eff = promoted;
    end else begin : g_masked
      assign eff = promoted & BANK_MASK;
    end
  endgenerate
endmodule

// File: rtl/cbc_nibram.sv
module cbc_nibram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 16,
  parameter int RAM_DEPTH = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [7:0]  rom_rdata,
  output logic [7:0]  cpu_rdata,
  output logic [17:0] rom_addr
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  logic [REG_W-1:0] bank_q;
  logic [REG_W-1:0] eff_bank;
  logic             ram_en;
  logic             reg_wr;
  logic             ram_we;
  logic [REG_W-1:0] ram_q;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[7:4];
  assign reg_wr = cpu_wr && in_reg_win(cpu_addr);
  assign ram_we = cpu_wr && in_ram_win(cpu_addr) && ram_en;

  cbc_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_gate  (reg_wr && !cpu_addr[8]),
    .wr_bank  (reg_wr && cpu_addr[8]),
    .wdata_lo (cpu_wdata[REG_W-1:0]),
    .bank_q   (bank_q),
    .ram_en   (ram_en)
  );

  cbc_bankmap #(.ROM_BANKS(ROM_BANKS), .REG_W(REG_W)) u_map (
    .raw (bank_q),
    .eff (eff_bank)
  );

  cbc_nibram #(.DEPTH(RAM_DEPTH), .WIDTH(REG_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (cpu_addr[RAM_AW-1:0]),
    .wdata (cpu_wdata[REG_W-1:0]),
    .rdata (ram_q)
  );

  assign rom_addr = {(cpu_addr[14] ? eff_bank : {REG_W{1'b0}}), cpu_addr[13:0]};

  always_comb begin
    cpu_rdata = IDLE_BYTE;
    if (cpu_rd) begin
      if (in_rom_win(cpu_addr))
        cpu_rdata = rom_rdata;
      else if (in_ram_win(cpu_addr) && ram_en)
        cpu_rdata = {4'hF, ram_q};
    end
  end
endmodule

// File: rtl/cbc_ctrl_chk.sv
module cbc_ctrl_chk #(
  parameter int ROM_BANKS = 16
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic        cpu_rd,
  input logic [7:0]  cpu_rdata,
  input logic [17:0] rom_addr,
  input logic [3:0]  bank_q,
  input logic        ram_en
);
  // R2
  low_window_bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_addr[14] |-> rom_addr[17:14] == 4'd0);

  // R3
  bank_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(rom_addr[17:14]) <= ROM_BANKS - 1);

  // R5
  gate_write_keeps_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:14] == 2'b00 && !cpu_addr[8]) |=> $stable(bank_q));

  // R5
  bank_write_keeps_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:14] == 2'b00 && cpu_addr[8]) |=> $stable(ram_en));

  // R8
  outside_write_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:14] != 2'b00) |=> ($stable(bank_q) && $stable(ram_en)));

  // R6
  ram_read_high_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:13] == 3'b101) |-> cpu_rdata[7:4] == 4'hF);

  // R7
  locked_ram_reads_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:13] == 3'b101 && !ram_en) |-> cpu_rdata == 8'hFF);

  // R9
  idle_bus_ff_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |-> cpu_rdata == 8'hFF);
endmodule

bind cbc_ctrl cbc_ctrl_chk #(.ROM_BANKS(ROM_BANKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_wr    (cpu_wr),
  .cpu_rd    (cpu_rd),
  .cpu_rdata (cpu_rdata),
  .rom_addr  (rom_addr),
  .bank_q    (bank_q),
  .ram_en    (ram_en)
);

// File: tb/cbc_ctrl_test.sv
`timescale 1ns/1ps
module cbc_ctrl_test;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  rom_rdata;
  logic [7:0]  cpu_rdata;
  logic [17:0] rom_addr;

  int n_checks = 0;
  int n_fail = 0;

  logic [3:0] bank_m;
  logic       en_m;
  logic [3:0] ram_m [512];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [17:0] x);
    return x[7:0] ^ {x[17:14], x[11:8]} ^ 8'h5A;
  endfunction

  assign rom_rdata = rom_byte(rom_addr);

  cbc_ctrl #(.ROM_BANKS(NB), .RAM_DEPTH(512)) uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_rdata(rom_rdata),
    .cpu_rdata(cpu_rdata), .rom_addr(rom_addr)
  );

  function automatic logic [3:0] eff_of(input logic [3:0] raw);
    logic [3:0] p;
    p = (raw == 4'd0) ? 4'd1 : raw;
    return p & 4'(NB - 1);
  endfunction

  function automatic logic [3:0] hi_of(input logic [15:0] a);
    return a[14] ? eff_of(bank_m) : 4'd0;
  endfunction

  function automatic logic [7:0] rd_of(input logic [15:0] a, input logic r);
    if (!r) return 8'hFF;
    if (a < 16'h8000) return rom_byte({hi_of(a), a[13:0]});
    if (a[15:13] == 3'b101) return en_m ? {4'hF, ram_m[a[8:0]]} : 8'hFF;
    return 8'hFF;
  endfunction

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic [7:0] d,
                        input logic w, input logic r, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = r;
    #1;
    check8(8'(rom_addr[17:14]), 8'(hi_of(a)), {tag, " R2/R3 bank lines"});
    if (rom_addr[13:0] !== a[13:0]) begin
      n_fail++;
      $display("FAIL R2 low lines: actual %h expected %h", rom_addr[13:0], a[13:0]);
    end
    check8(cpu_rdata, rd_of(a, r), {tag, " read data"});
    @(posedge clk);
    if (w) begin
      if (a[15:14] == 2'b00) begin
        if (a[8]) bank_m = d[3:0];
        else en_m = (d[3:0] == 4'hA);
      end else if (a[15:13] == 3'b101 && en_m) begin
        ram_m[a[8:0]] = d[3:0];
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    bank_m = 4'd0;
    en_m = 1'b0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    access(16'h4000, 8'h00, 1'b0, 1'b1, "R1 bank1 after reset");
    access(16'hA000, 8'h00, 1'b0, 1'b1, "R1 RAM locked after reset");
    // R2 fixed bank
    access(16'h3FFF, 8'h00, 1'b0, 1'b1, "R2 fixed window");
    // R4 unlock with upper nibble set, then fill RAM (R6)
    access(16'h0000, 8'h2A, 1'b1, 1'b0, "R4 unlock 0x2A");
    for (int i = 0; i < 512; i++)
      access(16'hA000 + 16'(i), 8'(i * 7 + 3), 1'b1, 1'b0, "R6 fill");
    access(16'hA000, 8'h00, 1'b0, 1'b1, "R6 read unlocked");
    access(16'hA200, 8'h00, 1'b0, 1'b1, "R6 mirror A200");
    access(16'hBFFF, 8'h00, 1'b0, 1'b1, "R6 mirror BFFF");
    // R7 locked writes ignored
    access(16'h00FF, 8'h50, 1'b1, 1'b0, "R4 lock");
    access(16'hA005, 8'h0C, 1'b1, 1'b1, "R7 locked write");
    access(16'hA005, 8'h00, 1'b0, 1'b1, "R7 locked read");
    access(16'h0000, 8'h0A, 1'b1, 1'b0, "R4 unlock");
    access(16'hA005, 8'h00, 1'b0, 1'b1, "R7 contents kept");
    // R3 bank select
    access(16'h0100, 8'h02, 1'b1, 1'b0, "R3 bank 2");
    access(16'h4123, 8'h00, 1'b0, 1'b1, "R3 read bank 2");
    access(16'h0100, 8'h05, 1'b1, 1'b0, "R3 bank 5 wraps");
    access(16'h7FFF, 8'h00, 1'b0, 1'b1, "R3 read wrapped");
    access(16'h2100, 8'h1F, 1'b1, 1'b0, "R3 bank 0x1F");
    access(16'h4000, 8'h00, 1'b0, 1'b1, "R3 read masked");
    access(16'h0100, 8'h00, 1'b1, 1'b0, "R3 bank 0 promoted");
    access(16'h4000, 8'h00, 1'b0, 1'b1, "R3 read promoted");
    // R5 isolation
    access(16'h0100, 8'h03, 1'b1, 1'b0, "R5 bank 3");
    access(16'h0000, 8'h05, 1'b1, 1'b0, "R5 gate write");
    access(16'h4000, 8'h00, 1'b0, 1'b1, "R5 bank kept");
    access(16'h0100, 8'h0A, 1'b1, 1'b0, "R5 bank write 0x0A");
    access(16'hA000, 8'h00, 1'b0, 1'b1, "R5 RAM still locked");
    // R8 outside writes
    access(16'h4000, 8'h0A, 1'b1, 1'b0, "R8 write ROM window");
    access(16'h9100, 8'h0A, 1'b1, 1'b0, "R8 write 9100");
    access(16'hC000, 8'h0A, 1'b1, 1'b0, "R8 write C000");
    access(16'hA000, 8'h00, 1'b0, 1'b1, "R8 RAM still locked");
    access(16'h4000, 8'h00, 1'b0, 1'b1, "R8 bank kept");
    // R9 unmapped and idle
    access(16'h8000, 8'h00, 1'b0, 1'b1, "R9 unmapped 8000");
    access(16'hE123, 8'h00, 1'b0, 1'b1, "R9 unmapped E123");
    access(16'h1234, 8'h00, 1'b0, 1'b0, "R9 rd low");

    for (int k = 0; k < 4000; k++) begin
      logic [15:0] a;
      logic [7:0]  d;
      logic        w;
      int sel;
      sel = int'($urandom % 6);
      d = 8'($urandom);
      w = 1'($urandom);
      case (sel)
        0: begin
          a = {2'b00, 14'($urandom)};
          a[8] = 1'b0;
          if ($urandom % 4 == 0) d[3:0] = 4'hA;
        end
        1: begin a = {2'b00, 14'($urandom)}; a[8] = 1'b1; end
        2: begin a = {1'b0, 15'($urandom)}; w = 1'b0; end
        3: a = {3'b101, 13'($urandom)};
        4: begin
          a = 16'($urandom);
          if (a[15:14] == 2'b00 || a[15:13] == 3'b101) a[15:13] = 3'b110;
        end
        default: begin a = {3'b101, 13'($urandom)}; w = 1'b0; end
      endcase
      access(a, d, w, 1'($urandom), "R1-R9 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule